// File: doc/BRIEF.md
# Packed Horizontal Add/Subtract Unit

This block combines neighbouring elements inside each of two packed operands. Element pairs (0,1), (2,3) and so on are added, or subtracted with the even element as minuend. The pair results are packed into a single vector: the results from the destination operand fill the lower half of the active width, and the results from the source operand fill the upper half. Elements are signed and may be 16 or 32 bits wide. For 16-bit elements, results either wrap modulo 2^16 or clamp to the signed 16-bit range. A width mode selects 64-bit or 128-bit operands.

The arithmetic is combinational. Each request enters through a valid/ready handshake and is captured in a single output register, which presents the result through a second valid/ready handshake. The request is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result is shown with `out_valid` high from the next cycle. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`!out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the held result does not change and no new request is taken.

Top module: `hpair_addsub_unit`

## Requirements
- R1: With `wide_mode`=1, `size_sel`=0 (16-bit) and `sub_sel`=0, 16-bit lane k of `out_vec` (k=0..3) holds dst element 2k + element 2k+1. Lane 4+k holds src element 2k + element 2k+1.
- R2: With `sub_sel`=1, every pair result is the even-indexed element minus the following odd-indexed element.
- R3: With `sat_en`=0 and 16-bit elements, each pair result is the low 16 bits of the exact signed result. For example, 0x7FFF+0x0001 gives 0x8000.
- R4: With `sat_en`=1 and 16-bit elements, each pair result is clamped to the range -32768..32767. For example, 0x7FFF+0x0001 gives 0x7FFF and 0x8000-0x0001 gives 0x8000.
- R5: With `size_sel`=1 (32-bit), `sat_en`=0 and `wide_mode`=1, 32-bit lanes 0 and 1 hold the dst pair results (elements 0,1 then 2,3), and lanes 2 and 3 hold the src pair results, each wrapping modulo 2^32.
- R6: With `wide_mode`=0, only bits 63:0 of each operand are used and bits 127:64 of `out_vec` are zero. For 16-bit elements, bits 63:0 hold d0 op d1, d2 op d3, s0 op s1, s2 op s3 from the low lane upward. For 32-bit elements, bits 31:0 hold d0 op d1 and bits 63:32 hold s0 op s1.
- R7: A request with `sat_en`=1 and `size_sel`=1 yields `out_illegal`=1 with `out_vec` all zero. Every other request yields `out_illegal`=0.
- R8: A request transfers on a rising edge with `in_valid` and `in_ready` both high, and `out_valid` is high in the following cycle. `in_ready` equals `!out_valid || out_ready`.
- R9: While `out_valid` is high and `out_ready` is low, `out_vec` and `out_illegal` hold their values and `out_valid` stays high.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| dst_vec | input | 128 | Destination operand; its pair results fill the lower half |
| src_vec | input | 128 | Source operand; its pair results fill the upper half |
| sub_sel | input | 1 | 1 = subtract (even minus odd), 0 = add |
| size_sel | input | 1 | 0 = 16-bit elements, 1 = 32-bit elements |
| sat_en | input | 1 | 1 = signed saturation (16-bit only) |
| wide_mode | input | 1 | 1 = 128-bit operands, 0 = 64-bit operands |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_vec | output | 128 | Packed pair results |
| out_illegal | output | 1 | Saturation was requested with 32-bit elements |

## Verification
The handshake assertions assume a well-behaved producer: the control and operand inputs are at known levels whenever `in_valid` is high. The bench drives every input on the falling edge, so nothing changes near a rising edge. The assertions on narrow-mode zeroing and on the illegal flag relate the request fields at acceptance to the output one cycle later. This assumes the consumer is not stalling on that edge, and the bench holds `out_ready` high except in the dedicated back-pressure sequence. Random operands are drawn with a bias toward 0x7FFF, 0x8000, 0xFFFF and 0x0000, and sizes and modes are drawn uniformly. As a result, clamping, wrapping and the illegal combination each occur many times.

// File: rtl/hpair_pkg.sv
package hpair_pkg;
  localparam int unsigned VEC_W_DEF = 128;
  localparam int unsigned NARROW_W  = 64;

  typedef enum logic {
    ELEM_16 = 1'b0,
    ELEM_32 = 1'b1
  } elem_sz_e;
endpackage

// File: rtl/hpair_lane.sv
module hpair_lane #(
  parameter int unsigned EW        = 16,
  parameter bit          ALLOW_SAT = 1'b1
) (
  input  logic [EW-1:0] even_el,
  input  logic [EW-1:0] odd_el,
  input  logic          sub_sel,
  input  logic          sat_en,
  output logic [EW-1:0] pair_res
);
  localparam logic [EW-1:0] MAX_POS = {1'b0, {(EW-1){1'b1}}};
  localparam logic [EW-1:0] MIN_NEG = {1'b1, {(EW-1){1'b0}}};

  logic [EW:0] ext_a, ext_b, ext_r;

  always_comb begin
    ext_a = {even_el[EW-1], even_el};
    ext_b = {odd_el[EW-1], odd_el};
    ext_r = sub_sel ? (ext_a - ext_b) : (ext_a + ext_b);
  end

  generate
    if (ALLOW_SAT) begin : g_sat
      always_comb begin
        if (sat_en && (ext_r[EW] != ext_r[EW-1]))
          pair_res = ext_r[EW] ? MIN_NEG : MAX_POS;
        else
          pair_res = ext_r[EW-1:0];
      end
    end else begin : g_wrap
      logic unused_sat;
      assign unused_sat = sat_en ^ ext_r[EW];
      assign pair_res   = ext_r[EW-1:0];
    end
  endgenerate
endmodule

// File: rtl/hpair_core.sv
module hpair_core #(
  parameter int unsigned VEC_W = hpair_pkg::VEC_W_DEF
) (
  input  logic [VEC_W-1:0] dst_vec,
  input  logic [VEC_W-1:0] src_vec,
  input  logic             sub_sel,
  input  logic             size_sel,
  input  logic             sat_en,
  input  logic             wide_mode,
  output logic [VEC_W-1:0] res_vec,
  output logic             res_illegal
);
  import hpair_pkg::*;

  localparam int unsigned NP16 = VEC_W / 32;
  localparam int unsigned NP32 = VEC_W / 64;
  localparam int unsigned NL16 = VEC_W / 16;
  localparam int unsigned NL32 = VEC_W / 32;

  logic [15:0] d16 [NP16];
  logic [15:0] s16 [NP16];
  logic [31:0] d32 [NP32];
  logic [31:0] s32 [NP32];
  logic [VEC_W-1:0] pack16, pack32;

  genvar k;
  generate
    for (k = 0; k < NP16; k++) begin : g_p16
      hpair_lane #(.EW(16), .ALLOW_SAT(1'b1)) u_d (
        .even_el(dst_vec[32*k +: 16]), .odd_el(dst_vec[32*k+16 +: 16]),
        .sub_sel(sub_sel), .sat_en(sat_en), .pair_res(d16[k]));
      hpair_lane #(.EW(16), .ALLOW_SAT(1'b1)) u_s (
        .even_el(src_vec[32*k +: 16]), .odd_el(src_vec[32*k+16 +: 16]),
        .sub_sel(sub_sel), .sat_en(sat_en), .pair_res(s16[k]));
    end
    for (k = 0; k < NP32; k++) begin : g_p32
      hpair_lane #(.EW(32), .ALLOW_SAT(1'b0)) u_d (
        .even_el(dst_vec[64*k +: 32]), .odd_el(dst_vec[64*k+32 +: 32]),
        .sub_sel(sub_sel), .sat_en(1'b0), .pair_res(d32[k]));
      hpair_lane #(.EW(32), .ALLOW_SAT(1'b0)) u_s (
        .even_el(src_vec[64*k +: 32]), .odd_el(src_vec[64*k+32 +: 32]),
        .sub_sel(sub_sel), .sat_en(1'b0), .pair_res(s32[k]));
    end

    for (k = 0; k < NL16; k++) begin : g_o16
      if (k < NP16 / 2) begin : g_lo
        assign pack16[16*k +: 16] = d16[k];
      end else if (k < NP16) begin : g_mid
        assign pack16[16*k +: 16] = wide_mode ? d16[k] : s16[k - NP16/2];
      end else begin : g_hi
        assign pack16[16*k +: 16] = wide_mode ? s16[k - NP16] : 16'h0;
      end
    end
    for (k = 0; k < NL32; k++) begin : g_o32
      if (k < NP32 / 2) begin : g_lo
        assign pack32[32*k +: 32] = d32[k];
      end else if (k < NP32) begin : g_mid
        assign pack32[32*k +: 32] = wide_mode ? d32[k] : s32[k - NP32/2];
      end else begin : g_hi
        assign pack32[32*k +: 32] = wide_mode ? s32[k - NP32] : 32'h0;
      end
    end
  endgenerate

  always_comb begin
    res_illegal = sat_en && (elem_sz_e'(size_sel) == ELEM_32);
    if (res_illegal)
      res_vec = '0;
    else if (elem_sz_e'(size_sel) == ELEM_32)
      res_vec = pack32;
    else
      res_vec = pack16;
  end
endmodule

// File: rtl/hpair_out_reg.sv
module hpair_out_reg #(
  parameter int unsigned DW = 129
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_load_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_drop_only_on_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));
endmodule

// File: rtl/hpair_addsub_unit.sv
module hpair_addsub_unit #(
  parameter int unsigned VEC_W = hpair_pkg::VEC_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] dst_vec,
  input  logic [VEC_W-1:0] src_vec,
  input  logic             sub_sel,
  input  logic             size_sel,
  input  logic             sat_en,
  input  logic             wide_mode,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_vec,
  output logic             out_illegal
);
  localparam int unsigned HALF_W = VEC_W / 2;

  logic [VEC_W-1:0] core_vec;
  logic             core_illegal;

  hpair_core #(.VEC_W(VEC_W)) u_core (
    .dst_vec(dst_vec), .src_vec(src_vec), .sub_sel(sub_sel),
    .size_sel(size_sel), .sat_en(sat_en), .wide_mode(wide_mode),
    .res_vec(core_vec), .res_illegal(core_illegal));

  hpair_out_reg #(.DW(VEC_W + 1)) u_oreg (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data({core_illegal, core_vec}), .out_valid(out_valid),
    .out_ready(out_ready), .out_data({out_illegal, out_vec}));

  assert_narrow_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !wide_mode) |=> (out_vec[VEC_W-1:HALF_W] == '0));

  assert_illegal_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && sat_en && size_sel) |=> (out_illegal && out_vec == '0));

  assert_legal_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !(sat_en && size_sel)) |=> !out_illegal);

  assert_ready_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

// File: tb/hpair_addsub_unit_tb_top.sv
module hpair_addsub_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [127:0] dst_vec = '0, src_vec = '0;
  logic sub_sel = 0, size_sel = 0, sat_en = 0, wide_mode = 1;
  logic out_valid, out_ready = 1'b1, out_illegal;
  logic [127:0] out_vec;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  hpair_addsub_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .dst_vec(dst_vec), .src_vec(src_vec), .sub_sel(sub_sel), .size_sel(size_sel),
    .sat_en(sat_en), .wide_mode(wide_mode), .out_valid(out_valid),
    .out_ready(out_ready), .out_vec(out_vec), .out_illegal(out_illegal));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [128:0] model(input logic [127:0] d, input logic [127:0] s,
                                         input logic sb, input logic sz,
                                         input logic st, input logic wd);
    logic [127:0] r = '0;
    int np;
    if (st && sz) return {1'b1, 128'h0};
    if (!sz) begin
      np = wd ? 4 : 2;
      for (int k = 0; k < np; k++) begin
        int a, b, x;
        a = int'($signed(d[32*k +: 16])); b = int'($signed(d[32*k+16 +: 16]));
        x = sb ? a - b : a + b;
        if (st) x = (x > 32767) ? 32767 : (x < -32768) ? -32768 : x;
        r[16*k +: 16] = x[15:0];
        a = int'($signed(s[32*k +: 16])); b = int'($signed(s[32*k+16 +: 16]));
        x = sb ? a - b : a + b;
        if (st) x = (x > 32767) ? 32767 : (x < -32768) ? -32768 : x;
        r[16*(np+k) +: 16] = x[15:0];
      end
    end else begin
      np = wd ? 2 : 1;
      for (int k = 0; k < np; k++) begin
        longint a, b, x;
        a = longint'($signed(d[64*k +: 32])); b = longint'($signed(d[64*k+32 +: 32]));
        x = sb ? a - b : a + b;
        r[32*k +: 32] = x[31:0];
        a = longint'($signed(s[64*k +: 32])); b = longint'($signed(s[64*k+32 +: 32]));
        x = sb ? a - b : a + b;
        r[32*(np+k) +: 32] = x[31:0];
      end
    end
    return {1'b0, r};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [128:0] act,
                       input logic [128:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [127:0] d, input logic [127:0] s, input logic sb,
                      input logic sz, input logic st, input logic wd, input string tag);
    logic [128:0] exp;
    @(negedge clk);
    dst_vec = d; src_vec = s; sub_sel = sb; size_sel = sz; sat_en = st; wide_mode = wd;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    exp = model(d, s, sb, sz, st, wd);
    check(out_valid === 1'b1, {tag, " valid R8"}, {128'h0, out_valid}, 129'h1);
    check({out_illegal, out_vec} === exp, tag, {out_illegal, out_vec}, exp);
  endtask

  function automatic logic [15:0] pick16();
    case ($urandom % 6)
      0: return 16'h7FFF;
      1: return 16'h8000;
      2: return 16'hFFFF;
      3: return 16'h0000;
      default: return 16'($urandom);
    endcase
  endfunction

  function automatic logic [127:0] rvec();
    logic [127:0] v;
    for (int i = 0; i < 8; i++) v[16*i +: 16] = pick16();
    return v;
  endfunction

  initial begin
    logic [128:0] hold_a;
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R10 out_valid after reset", {128'h0, out_valid}, 129'h0);
    check(in_ready === 1'b1, "R10 in_ready after reset", {128'h0, in_ready}, 129'h1);

    send(128'h0008_0007_0006_0005_0004_0003_0002_0001,
         128'h0080_0070_0060_0050_0040_0030_0020_0010, 0, 0, 0, 1, "R1 wide add16 order");
    send(128'h0001_0009_0002_0005_0003_0004_0001_0010,
         128'h0005_0001_0007_0003_0002_0008_0004_0006, 1, 0, 0, 1, "R2 sub even-odd");
    send({96'h0, 32'h0001_7FFF}, {96'h0, 32'h0001_8000}, 0, 0, 0, 1, "R3 wrap add16");
    send({96'h0, 32'h0001_7FFF}, {96'h0, 32'h0001_8000}, 1, 0, 0, 1, "R3 wrap sub16");
    send({96'h0, 32'h0001_7FFF}, {96'h0, 32'h8000_8000}, 0, 0, 1, 1, "R4 sat add16");
    send({96'h0, 32'h0001_8000}, {96'h0, 32'h8000_7FFF}, 1, 0, 1, 1, "R4 sat sub16");
    send(128'h0000_0001_FFFF_FFFF_0000_0002_7FFF_FFFF,
         128'h0000_0005_0000_0003_8000_0000_0000_0001, 0, 1, 0, 1, "R5 wide add32 wrap");
    send(128'h0000_0001_FFFF_FFFF_0000_0002_7FFF_FFFF,
         128'h0000_0005_0000_0003_8000_0000_0000_0001, 1, 1, 0, 1, "R5 wide sub32");
    send(128'hDEAD_BEEF_CAFE_F00D_1234_5678_0004_0003,
         128'hFFFF_EEEE_DDDD_CCCC_0040_0030_0020_0010, 0, 0, 0, 0, "R6 narrow add16");
    send(128'hDEAD_BEEF_CAFE_F00D_0000_0002_0000_0009,
         128'hFFFF_EEEE_DDDD_CCCC_0000_0001_0000_0005, 1, 1, 0, 0, "R6 narrow sub32");
    send(128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
         128'h1111_1111_1111_1111_1111_1111_1111_1111, 0, 1, 1, 1, "R7 illegal sat32");

    // back-pressure
    @(negedge clk);
    dst_vec = 128'h0003_0002; src_vec = 128'h0; sub_sel = 0; size_sel = 0; sat_en = 0;
    wide_mode = 1; in_valid = 1'b1; out_ready = 1'b0;
    hold_a = model(dst_vec, src_vec, 0, 0, 0, 1);
    @(negedge clk);
    check({out_illegal, out_vec} === hold_a, "R8 first accept", {out_illegal, out_vec}, hold_a);
    dst_vec = 128'h0100_0200; src_vec = 128'h0300_0400;
    check(in_ready === 1'b0, "R8 in_ready low when stalled", {128'h0, in_ready}, 129'h0);
    repeat (3) begin
      @(negedge clk);
      check(out_valid === 1'b1 && {out_illegal, out_vec} === hold_a, "R9 hold under stall",
            {out_illegal, out_vec}, hold_a);
    end
    out_ready = 1'b1;
    #1;
    check(in_ready === 1'b1, "R8 in_ready with out_ready", {128'h0, in_ready}, 129'h1);
    hold_a = model(dst_vec, src_vec, 0, 0, 0, 1);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && {out_illegal, out_vec} === hold_a, "R8 second item",
          {out_illegal, out_vec}, hold_a);
    @(negedge clk);
    check(out_valid === 1'b0, "R8 drained", {128'h0, out_valid}, 129'h0);

    for (int n = 0; n < 400; n++) begin
      logic [3:0] c;
      c = 4'($urandom);
      send(rvec(), rvec(), c[0], c[1], c[2], c[3], "R1 R2 R3 R4 R5 R6 R7 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule